// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block owns the segment and pointer registers of a 16-bit real-mode core (code segment, instruction pointer, stack segment, stack pointer and the flags word). It runs the opcode fetch loop and, at an instruction boundary, turns a pending interrupt into the full entry sequence. Every fetch reads one byte at the linear address formed from the code segment shifted left by four plus the instruction pointer, and then advances the instruction pointer. Each fetch is treated as one instruction, so the cycle in which the sequencer picks its next action is the boundary.

A raised interrupt is latched together with its 8-bit vector. At the next boundary the sequencer pushes three words onto the stack and reads two words from the vector table. The stack words are the flags, then the code segment, then the instruction pointer. The new code segment comes from vector*4+2 and the new instruction pointer from vector*4. The interrupt-enable and trap bits are cleared after the flags are pushed. A one-cycle done pulse marks the end of entry.

A halt request stops the loop for good, and it wins over any pending interrupt. All memory traffic goes through one port with a request/ready handshake. The execution side can overwrite the register set at a boundary through a load strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: A pulse on `intReq` latches `intVec`; when the gate of R4 is open, entry starts at the next boundary and no opcode fetch is issued before entry completes.
- R2: Entry makes exactly five memory accesses in this order: write flags, write CS, read word at vector*4+2, write IP, read word at vector*4. The pushed CS and IP are the values held before entry.
- R3: The pushed flags word is the value held before entry. After entry, flags bit 9 (interrupt enable) and bit 8 (trap) are 0 and the other bits are unchanged.
- R4: Vectors 0 and 2 are serviced whatever the value of flags bit 9. Any other vector stays pending while bit 9 is 0, with fetching going on, and is serviced at the first boundary after bit 9 becomes 1.
- R5: Each push first lowers SP by 2, modulo 65536, and writes the word at (SS<<4)+SP. All linear addresses are taken modulo 2^20.
- R6: After entry, CS holds the word read from vector*4+2 and IP holds the word read from vector*4. The pending request is cleared, so entry happens once per raise and fetching resumes at the new CS:IP.
- R7: `entryDone` is high for exactly one cycle, in the cycle after the last vector-table read is accepted.
- R8: A halt request (`haltReq`) takes priority over a pending interrupt and over a register load. `halted` then stays high and no further memory request is made.
- R9: A fetch is a byte read (`memWord`=0, `memWe`=0) at (CS<<4)+IP. Once it is accepted, IP increases by 1 and `opValid` pulses for one cycle with `opByte` equal to the low byte of `memRdata`.
- R10: An access completes only on a clock edge where `memReq` and `memReady` are both high. Until then, the request, address, direction and write data hold steady.
- R11: During and right after reset there is no memory request, `halted`, `entryDone` and `opValid` are 0, and the registers hold their reset parameters (CS F000, IP FFF0, SS 0000, SP 0000, flags 0002 by default).
- R12: `archWe` at a boundary loads all five registers from the `arch*` inputs. It takes priority over interrupt entry and over fetching, so an interrupt raised in the same cycle enters with the loaded values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intReq | input | 1 | Raise interrupt (one-cycle pulse) |
| intVec | input | 8 | Vector number latched with `intReq` |
| haltReq | input | 1 | Request to halt the fetch loop |
| archWe | input | 1 | Load the register set at a boundary |
| archCs | input | 16 | Code segment to load |
| archIp | input | 16 | Instruction pointer to load |
| archSs | input | 16 | Stack segment to load |
| archSp | input | 16 | Stack pointer to load |
| archFlags | input | 16 | Flags word to load |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memWord | output | 1 | 1 = 16-bit access, 0 = byte access |
| memAddr | output | 20 | Linear byte address |
| memWdata | output | 16 | Write data |
| memReady | input | 1 | Memory accepts the access at this edge |
| memRdata | input | 16 | Read data, valid while `memReady` is high |
| opValid | output | 1 | An opcode byte was fetched |
| opByte | output | 8 | The fetched opcode byte |
| entryDone | output | 1 | Interrupt entry completed (one cycle) |
| halted | output | 1 | Fetch loop stopped |
| curCs | output | 16 | Current code segment |
| curIp | output | 16 | Current instruction pointer |
| curSs | output | 16 | Current stack segment |
| curSp | output | 16 | Current stack pointer |
| curFlags | output | 16 | Current flags word |

## Verification
The bench targets the following corner cases, each with the way a faulty design would show up:
- Stack pointer 0, which must wrap to FFFE. A design that does not wrap would write outside the stack segment.
- A stack segment near the top of memory, where the linear address must wrap. Without the wrap, the write address would carry into a 21st bit.
- Vectors 0 and 2 with interrupts disabled. A design that gates them on the enable bit would never finish entry.
- A gated vector that must wait while fetching goes on, then enter with the instruction pointer the fetches advanced. A wrong design would enter early or push a stale IP.
- A halt raised together with an interrupt and a load. A wrong priority would show up as stack traffic or changed registers after the halt.
- Random ready stalls on every access, which expose any request that moves or any register that updates before its access is accepted.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned SEG_W  = 16;
  localparam int unsigned LIN_W  = 20;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IF_BIT = 9;
  localparam int unsigned TF_BIT = 8;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_FETCH, ACC_PUSH_FL, ACC_PUSH_CS, ACC_RD_CS, ACC_PUSH_IP, ACC_RD_IP
  } accKind_e;

  typedef struct packed {
    logic     loadArch;
    logic     ack;
    accKind_e kind;
  } dpStrobe_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             intReq,
  input  logic [VEC_W-1:0] intVec,
  input  logic             haltReq,
  input  logic             archWe,
  input  logic             memReady,
  input  logic             ifFlag,
  output dpStrobe_t        strobe,
  output logic [VEC_W-1:0] pendVec,
  output logic             memReq,
  output logic             memWe,
  output logic             memWord,
  output logic             opValid,
  output logic             entryDone,
  output logic             halted
);
  typedef enum logic [2:0] {
    ST_RUN, ST_FETCH, ST_PFL, ST_PCS, ST_RCS, ST_PIP, ST_RIP, ST_HALT
  } state_e;

  state_e   state, stateNext;
  accKind_e kind;
  logic     pending, haltFlag, hasHalt, gateOpen, ack;

  always_comb begin
    unique case (state)
      ST_FETCH: kind = ACC_FETCH;
      ST_PFL:   kind = ACC_PUSH_FL;
      ST_PCS:   kind = ACC_PUSH_CS;
      ST_RCS:   kind = ACC_RD_CS;
      ST_PIP:   kind = ACC_PUSH_IP;
      ST_RIP:   kind = ACC_RD_IP;
      default:  kind = ACC_NONE;
    endcase
  end

  assign memReq   = (kind != ACC_NONE);
  assign memWe    = (kind == ACC_PUSH_FL) || (kind == ACC_PUSH_CS) || (kind == ACC_PUSH_IP);
  assign memWord  = memReq && (kind != ACC_FETCH);
  assign ack      = memReq && memReady;
  assign hasHalt  = haltFlag || haltReq;
  assign gateOpen = pending && ((pendVec == VEC_W'(0)) || (pendVec == VEC_W'(2)) || ifFlag);
  assign halted   = (state == ST_HALT);

  assign strobe.loadArch = (state == ST_RUN) && !hasHalt && archWe;
  assign strobe.ack      = ack;
  assign strobe.kind     = kind;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (hasHalt)       stateNext = ST_HALT;
        else if (archWe)   stateNext = ST_RUN;
        else if (gateOpen) stateNext = ST_PFL;
        else               stateNext = ST_FETCH;
      end
      ST_FETCH: if (ack) stateNext = ST_RUN;
      ST_PFL:   if (ack) stateNext = ST_PCS;
      ST_PCS:   if (ack) stateNext = ST_RCS;
      ST_RCS:   if (ack) stateNext = ST_PIP;
      ST_PIP:   if (ack) stateNext = ST_RIP;
      ST_RIP:   if (ack) stateNext = ST_RUN;
      default:  stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_RUN;
      pending   <= 1'b0;
      pendVec   <= '0;
      haltFlag  <= 1'b0;
      opValid   <= 1'b0;
      entryDone <= 1'b0;
    end else begin
      state     <= stateNext;
      opValid   <= (kind == ACC_FETCH) && ack;
      entryDone <= (kind == ACC_RD_IP) && ack;
      if (haltReq) haltFlag <= 1'b1;
      if (intReq) begin
        pending <= 1'b1;
        pendVec <= intVec;
      end else if ((kind == ACC_RD_IP) && ack) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter logic [SEG_W-1:0] RST_CS    = 16'hF000,
  parameter logic [SEG_W-1:0] RST_IP    = 16'hFFF0,
  parameter logic [SEG_W-1:0] RST_SS    = 16'h0000,
  parameter logic [SEG_W-1:0] RST_SP    = 16'h0000,
  parameter logic [SEG_W-1:0] RST_FLAGS = 16'h0002
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [VEC_W-1:0]  vec,
  input  logic [SEG_W-1:0]  archCs,
  input  logic [SEG_W-1:0]  archIp,
  input  logic [SEG_W-1:0]  archSs,
  input  logic [SEG_W-1:0]  archSp,
  input  logic [SEG_W-1:0]  archFlags,
  input  logic [SEG_W-1:0]  memRdata,
  output logic [LIN_W-1:0]  memAddr,
  output logic [SEG_W-1:0]  memWdata,
  output logic [BYTE_W-1:0] opByte,
  output logic              ifFlag,
  output logic [SEG_W-1:0]  curCs,
  output logic [SEG_W-1:0]  curIp,
  output logic [SEG_W-1:0]  curSs,
  output logic [SEG_W-1:0]  curSp,
  output logic [SEG_W-1:0]  curFlags
);
  logic [SEG_W-1:0] spDown;

  function automatic logic [LIN_W-1:0] toLinear(input logic [SEG_W-1:0] seg,
                                                input logic [SEG_W-1:0] off);
    return LIN_W'({seg, 4'b0000}) + LIN_W'(off);
  endfunction

  assign spDown = curSp - SEG_W'(2);
  assign ifFlag = curFlags[IF_BIT];

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    unique case (strobe.kind)
      ACC_FETCH:   memAddr = toLinear(curCs, curIp);
      ACC_PUSH_FL: begin memAddr = toLinear(curSs, spDown); memWdata = curFlags; end
      ACC_PUSH_CS: begin memAddr = toLinear(curSs, spDown); memWdata = curCs;    end
      ACC_PUSH_IP: begin memAddr = toLinear(curSs, spDown); memWdata = curIp;    end
      ACC_RD_CS:   memAddr = LIN_W'({vec, 2'b10});
      ACC_RD_IP:   memAddr = LIN_W'({vec, 2'b00});
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCs    <= RST_CS;
      curIp    <= RST_IP;
      curSs    <= RST_SS;
      curSp    <= RST_SP;
      curFlags <= RST_FLAGS;
      opByte   <= '0;
    end else if (strobe.loadArch) begin
      curCs    <= archCs;
      curIp    <= archIp;
      curSs    <= archSs;
      curSp    <= archSp;
      curFlags <= archFlags;
    end else if (strobe.ack) begin
      unique case (strobe.kind)
        ACC_FETCH: begin
          curIp  <= curIp + SEG_W'(1);
          opByte <= memRdata[BYTE_W-1:0];
        end
        ACC_PUSH_FL: begin
          curSp            <= spDown;
          curFlags[IF_BIT] <= 1'b0;
          curFlags[TF_BIT] <= 1'b0;
        end
        ACC_PUSH_CS: curSp <= spDown;
        ACC_PUSH_IP: curSp <= spDown;
        ACC_RD_CS:   curCs <= memRdata;
        ACC_RD_IP:   curIp <= memRdata;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [15:0] RST_CS    = 16'hF000,
  parameter logic [15:0] RST_IP    = 16'hFFF0,
  parameter logic [15:0] RST_SS    = 16'h0000,
  parameter logic [15:0] RST_SP    = 16'h0000,
  parameter logic [15:0] RST_FLAGS = 16'h0002
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        intReq,
  input  logic [7:0]  intVec,
  input  logic        haltReq,
  input  logic        archWe,
  input  logic [15:0] archCs,
  input  logic [15:0] archIp,
  input  logic [15:0] archSs,
  input  logic [15:0] archSp,
  input  logic [15:0] archFlags,
  output logic        memReq,
  output logic        memWe,
  output logic        memWord,
  output logic [19:0] memAddr,
  output logic [15:0] memWdata,
  input  logic        memReady,
  input  logic [15:0] memRdata,
  output logic        opValid,
  output logic [7:0]  opByte,
  output logic        entryDone,
  output logic        halted,
  output logic [15:0] curCs,
  output logic [15:0] curIp,
  output logic [15:0] curSs,
  output logic [15:0] curSp,
  output logic [15:0] curFlags
);
  dpStrobe_t        strobe;
  logic [VEC_W-1:0] pendVec;
  logic             ifFlag;

  irq_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .intReq(intReq), .intVec(intVec), .haltReq(haltReq),
    .archWe(archWe), .memReady(memReady), .ifFlag(ifFlag), .strobe(strobe),
    .pendVec(pendVec), .memReq(memReq), .memWe(memWe), .memWord(memWord),
    .opValid(opValid), .entryDone(entryDone), .halted(halted)
  );

  irq_entry_dp #(
    .RST_CS(RST_CS), .RST_IP(RST_IP), .RST_SS(RST_SS), .RST_SP(RST_SP), .RST_FLAGS(RST_FLAGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vec(pendVec),
    .archCs(archCs), .archIp(archIp), .archSs(archSs), .archSp(archSp), .archFlags(archFlags),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .opByte(opByte),
    .ifFlag(ifFlag), .curCs(curCs), .curIp(curIp), .curSs(curSs), .curSp(curSp),
    .curFlags(curFlags)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memReady,
  input logic        memWe,
  input logic [19:0] memAddr,
  input logic [15:0] memWdata,
  input logic        entryDone,
  input logic        halted,
  input logic [15:0] curSp,
  input logic [15:0] curFlags
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |=> !entryDone);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && !memReq);

  // R5
  push_sp_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && memWe |=> curSp == $past(curSp) - 16'd2);

  // R3
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> !curFlags[9] && !curFlags[8]);
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memReady(memReady), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .entryDone(entryDone), .halted(halted),
  .curSp(curSp), .curFlags(curFlags)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intReq = 1'b0, haltReq = 1'b0, archWe = 1'b0;
  logic [7:0]  intVec = '0;
  logic [15:0] archCs = '0, archIp = '0, archSs = '0, archSp = '0, archFlags = '0;
  logic memReq, memWe, memWord, memReady = 1'b1;
  logic [19:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic opValid, entryDone, halted;
  logic [7:0] opByte;
  logic [15:0] curCs, curIp, curSs, curSp, curFlags;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit readyRand = 0;

  // bench model state
  logic [15:0] expCs, expIp;
  logic [7:0]  lastFetchByte;
  int fetchCount, doneCount, accN;
  logic        accWe   [0:15];
  logic [19:0] accAddr [0:15];
  logic [15:0] accData [0:15];
  bit          prevStall;
  logic [19:0] prevAddr;
  logic        prevWe;

  always #4 clk = ~clk;

  function automatic logic [15:0] memFn(input logic [19:0] a);
    return a[15:0] ^ {a[3:0], a[19:8]} ^ 16'hA55A;
  endfunction

  function automatic logic [19:0] lin(input logic [15:0] s, input logic [15:0] o);
    return ({4'b0000, s} << 4) + {4'b0000, o};
  endfunction

  assign memRdata = memFn(memAddr);

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rstN(rstN), .intReq(intReq), .intVec(intVec), .haltReq(haltReq),
    .archWe(archWe), .archCs(archCs), .archIp(archIp), .archSs(archSs), .archSp(archSp),
    .archFlags(archFlags), .memReq(memReq), .memWe(memWe), .memWord(memWord),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .opValid(opValid), .opByte(opByte), .entryDone(entryDone), .halted(halted),
    .curCs(curCs), .curIp(curIp), .curSs(curSs), .curSp(curSp), .curFlags(curFlags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder and port monitor
  always @(negedge clk) begin
    logic [15:0] w;
    if (!rstN) begin
      prevStall = 0;
      memReady  = 1'b1;
    end else begin
      if (prevStall) chk(memReq && memAddr == prevAddr && memWe == prevWe, "R10 request held", {11'b0, memReq, memAddr}, {12'b1, prevAddr});
      if (opValid) chk(opByte == lastFetchByte, "R9 opByte", opByte, lastFetchByte);
      if (entryDone) doneCount++;
      memReady = readyRand ? ($urandom % 3 != 0) : 1'b1;
      if (memReq && memReady) begin
        if (!memWord) begin
          chk(!memWe && memAddr == lin(expCs, expIp), "R9 fetch address", memAddr, lin(expCs, expIp));
          w = memFn(memAddr);
          lastFetchByte = w[7:0];
          expIp = expIp + 16'd1;
          fetchCount++;
        end else if (accN < 16) begin
          accWe[accN]   = memWe;
          accAddr[accN] = memAddr;
          accData[accN] = memWe ? memWdata : memRdata;
          accN++;
        end
      end
      prevStall = memReq && !memReady;
      prevAddr  = memAddr;
      prevWe    = memWe;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic clearLog();
    accN = 0; fetchCount = 0; doneCount = 0;
  endtask

  task automatic startScenario(input logic [7:0] vec, input logic [15:0] cs, ip, ss, sp, fl,
                               input bit raise, input bit hlt);
    rstN = 1'b0; archWe = 1'b0; intReq = 1'b0; haltReq = 1'b0;
    tick(); tick();
    archCs = cs; archIp = ip; archSs = ss; archSp = sp; archFlags = fl;
    archWe = 1'b1; intReq = raise; intVec = vec; haltReq = hlt;
    expCs = cs; expIp = ip;
    clearLog();
    rstN = 1'b1;
    tick();
    archWe = 1'b0; intReq = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      if (doneCount > 0) begin ok = 1; break; end
      tick();
    end
  endtask

  task automatic checkEntry(input logic [7:0] vec, input logic [15:0] cs, ip, ss, sp, fl);
    logic [15:0] s1, s2, s3, nCs, nIp;
    s1 = sp - 16'd2; s2 = sp - 16'd4; s3 = sp - 16'd6;
    nCs = memFn({10'b0, vec, 2'b10});
    nIp = memFn({10'b0, vec, 2'b00});
    chk(accN == 5, "R2 access count", accN, 5);
    chk(accWe[0] && accAddr[0] == lin(ss, s1), "R5 flags push address", accAddr[0], lin(ss, s1));
    chk(accData[0] == fl, "R3 pushed flags", accData[0], fl);
    chk(accWe[1] && accAddr[1] == lin(ss, s2) && accData[1] == cs, "R2 CS push", {accAddr[1], accData[1][11:0]}, {lin(ss, s2), cs[11:0]});
    chk(!accWe[2] && accAddr[2] == {10'b0, vec, 2'b10}, "R2 CS vector read", accAddr[2], {10'b0, vec, 2'b10});
    chk(accWe[3] && accAddr[3] == lin(ss, s3) && accData[3] == ip, "R2 IP push", {accAddr[3], accData[3][11:0]}, {lin(ss, s3), ip[11:0]});
    chk(!accWe[4] && accAddr[4] == {10'b0, vec, 2'b00}, "R2 IP vector read", accAddr[4], {10'b0, vec, 2'b00});
    chk(curCs == nCs && curIp == nIp, "R6 new CS:IP", {curCs, curIp}, {nCs, nIp});
    chk(curSp == s3 && curSs == ss, "R5 final SP", curSp, s3);
    chk(curFlags == (fl & 16'hFCFF), "R3 flags after entry", curFlags, fl & 16'hFCFF);
    expCs = nCs; expIp = nIp;
    tick();
    chk(entryDone == 1'b0, "R7 done width", entryDone, 0);
    repeat (12) tick();
    chk(doneCount == 1, "R6 single entry", doneCount, 1);
    chk(fetchCount > 0, "R6 fetch resumes", fetchCount, 1);
  endtask

  task automatic runEntry(input logic [7:0] vec, input logic [15:0] cs, ip, ss, sp, fl);
    bit ok;
    startScenario(vec, cs, ip, ss, sp, fl, 1'b1, 1'b0);
    chk(curCs == cs && curIp == ip && curSs == ss && curSp == sp && curFlags == fl,
        "R12 load", {curCs, curIp}, {cs, ip});
    waitDone(ok);
    chk(ok, "R1 entry completes", ok, 1);
    chk(fetchCount == 0, "R1 no fetch before entry", fetchCount, 0);
    if (ok) checkEntry(vec, cs, ip, ss, sp, fl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual expired expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [7:0] v;
    logic [15:0] fl, ipNow;
    void'($urandom(32'd20240611));
    clearLog();
    rstN = 1'b0;
    tick(); tick();
    // R11 reset state
    chk(!memReq && !halted && !entryDone && !opValid, "R11 idle outputs", {memReq, halted, entryDone, opValid}, 0);
    chk(curCs == 16'hF000 && curIp == 16'hFFF0, "R11 reset CS:IP", {curCs, curIp}, 32'hF000FFF0);
    chk(curSs == 16'h0 && curSp == 16'h0 && curFlags == 16'h0002, "R11 reset SS/SP/flags", {curSp, curFlags}, 32'h00000002);

    // R4: vectors 0 and 2 ignore the enable bit
    runEntry(8'd0, 16'h1234, 16'h0100, 16'h2000, 16'h0100, 16'h0102);
    runEntry(8'd2, 16'hABCD, 16'h7FFF, 16'h3000, 16'h0000, 16'h08C3);   // R5 SP wrap
    // R5 linear address wrap at 2^20
    runEntry(8'hFF, 16'hFFFF, 16'hFFFE, 16'hFFFF, 16'h0020, 16'h0202);

    // R4 gated vector waits while fetching continues
    startScenario(8'd5, 16'h0400, 16'h0010, 16'h0500, 16'h0200, 16'h0002, 1'b1, 1'b0);
    repeat (30) tick();
    chk(doneCount == 0 && accN == 0, "R4 gated vector held", doneCount, 0);
    chk(fetchCount > 0, "R4 fetching while gated", fetchCount, 1);
    ok = 0;
    for (int i = 0; i < 20 && !ok; i++) begin
      if (!memReq && !halted) ok = 1; else tick();
    end
    ipNow = expIp;
    archCs = 16'h0400; archIp = ipNow; archSs = 16'h0500; archSp = 16'h0200; archFlags = 16'h0202;
    archWe = 1'b1;
    accN = 0; fetchCount = 0;
    tick();
    archWe = 1'b0;
    waitDone(ok);
    chk(ok, "R4 entry after enable", ok, 1);
    chk(fetchCount == 0, "R1 boundary after enable", fetchCount, 0);
    if (ok) checkEntry(8'd5, 16'h0400, ipNow, 16'h0500, 16'h0200, 16'h0202);

    // R8 halt beats interrupt and load
    startScenario(8'd3, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0202, 1'b1, 1'b1);
    haltReq = 1'b0;
    repeat (20) tick();
    chk(halted == 1'b1, "R8 halted", halted, 1);
    chk(accN == 0 && fetchCount == 0 && doneCount == 0, "R8 no traffic", accN + fetchCount, 0);
    chk(curCs == 16'hF000 && curIp == 16'hFFF0, "R8 load blocked", {curCs, curIp}, 32'hF000FFF0);

    // R10 random scenarios with ready stalls
    readyRand = 1;
    for (int n = 0; n < 40; n++) begin
      v  = 8'($urandom);
      fl = 16'($urandom);
      if (v != 8'd0 && v != 8'd2) fl[9] = 1'b1;
      runEntry(v, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), fl);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule